// File: doc/BRIEF.md
# Comma Aligner with Dual 8b/10b Symbol Decoder

This block receives an 8b/10b coded bit stream one bit at a time, qualified by a bit strobe. It searches the stream for the positive-polarity comma and uses it to fix the word boundary. From then on it cuts the stream into 20-bit words. Each word holds two 10-bit symbols, and each symbol is decoded into a byte and a control flag. The symbol that carried the comma goes to the low byte lane.

Decoding checks running disparity across the two symbols of a word and from one word to the next. Only twelve control characters are accepted. A symbol that is malformed, that breaks disparity, or that is a control character outside that set is replaced by an all-zero control byte in its own lane only. A loss-of-signal input overrides both lanes with all-ones control bytes. The block is meant to sit behind a clock-recovery front end that supplies retimed bits and a loss-of-signal indication.

Top module: `sym_align_decode`

## Requirements
- R1: Alignment is taken only on the bit sequence 0,0,1,1,1,1,1 received in that order. The inverted sequence 1,1,0,0,0,0,0 never sets or moves the word boundary.
- R2: Bits arrive first-bit-first. In a symbol the first received bit is code bit a and the tenth is j. The symbol received first in a word decodes to `word_data[7:0]` and the second to `word_data[15:8]`. A decoded byte is {HGF, EDCBA}, so K28.5 reads 0xBC. The comma symbol always lands in the low lane.
- R3: The accepted control characters are K28.0 to K28.7 (0x1C, 0x3C, … 0xFC), K23.7 (0xF7), K27.7 (0xFB), K29.7 (0xFD) and K30.7 (0xFE). For these the lane flag (`ctl_lo` for the low byte, `ctl_hi` for the high byte) is 1. For data bytes it is 0.
- R4: An undecodable symbol, including a control code outside the accepted set, makes its own lane read flag 1 with byte 0x00. The other lane of the same word is decoded normally.
- R5: Running disparity starts negative at every alignment. It is carried from the low symbol to the high symbol and from word to word. A symbol that is valid only under the opposite disparity counts as a decode error under R4.
- R6: In the cycle after `los` is sampled high, `word_data` reads 0xFFFF and both flags read 1. A word completed while `los` is high also carries that value.
- R7: `word_valid` pulses for one cycle, in the cycle after the twentieth valid bit of an aligned word. Outputs hold their value between words while `los` is low.
- R8: A bit is taken only on a clock edge where `bit_vld` is high. `ser_bit` is ignored otherwise.
- R9: `word_valid` stays low from reset until the first comma has been received.
- R10: A comma that ends exactly on a symbol boundary of the current alignment, in either lane, leaves the alignment unchanged. A comma anywhere else realigns the stream, and the partial word that was in progress is discarded.
- R11: After reset, `word_data` is 0x0000, both flags are 0 and `word_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_bit | input | 1 | Serial code bit |
| bit_vld | input | 1 | `ser_bit` is valid this cycle |
| los | input | 1 | Loss of signal |
| word_data | output | 16 | Decoded word, low lane in bits 7:0 |
| ctl_lo | output | 1 | Low byte is a control character |
| ctl_hi | output | 1 | High byte is a control character |
| word_valid | output | 1 | One-cycle strobe for a new word |

## Verification
The hardest case to reach from the ports is a comma that turns up off the established boundary in the middle of a running stream. The stimulus reaches it by inserting a few stray bits after a complete word, then sending a fresh comma word. The words that follow must then decode at the new boundary. The negative-polarity comma case is reached by streaming inverted comma symbols from reset and confirming that no word appears. Disparity errors are produced by sending one symbol in the opposite disparity form while the encoder's own tracking stays unchanged. The neighbouring lane must still decode cleanly.

// File: rtl/sym_align_decode.sv
module sym_align_decode (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_bit,
  input  logic        bit_vld,
  input  logic        los,
  output logic [15:0] word_data,
  output logic        ctl_lo,
  output logic        ctl_hi,
  output logic        word_valid
);

  localparam int SYM = 10;
  localparam int WRD = 2 * SYM;
  localparam int CW  = $clog2(WRD + 1);

  function automatic logic [5:0] t6(input logic [4:0] x);
    case (x)
      5'd0:  t6 = 6'b100111;  5'd1:  t6 = 6'b011101;
      5'd2:  t6 = 6'b101101;  5'd3:  t6 = 6'b110001;
      5'd4:  t6 = 6'b110101;  5'd5:  t6 = 6'b101001;
      5'd6:  t6 = 6'b011001;  5'd7:  t6 = 6'b111000;
      5'd8:  t6 = 6'b111001;  5'd9:  t6 = 6'b100101;
      5'd10: t6 = 6'b010101;  5'd11: t6 = 6'b110100;
      5'd12: t6 = 6'b001101;  5'd13: t6 = 6'b101100;
      5'd14: t6 = 6'b011100;  5'd15: t6 = 6'b010111;
      5'd16: t6 = 6'b011011;  5'd17: t6 = 6'b100011;
      5'd18: t6 = 6'b010011;  5'd19: t6 = 6'b110010;
      5'd20: t6 = 6'b001011;  5'd21: t6 = 6'b101010;
      5'd22: t6 = 6'b011010;  5'd23: t6 = 6'b111010;
      5'd24: t6 = 6'b110011;  5'd25: t6 = 6'b100110;
      5'd26: t6 = 6'b010110;  5'd27: t6 = 6'b110110;
      5'd28: t6 = 6'b001110;  5'd29: t6 = 6'b101110;
      5'd30: t6 = 6'b011110;  default: t6 = 6'b101011;
    endcase
  endfunction

  function automatic logic [3:0] t4(input logic [2:0] y);
    case (y)
      3'd0: t4 = 4'b1011;  3'd1: t4 = 4'b1001;
      3'd2: t4 = 4'b0101;  3'd3: t4 = 4'b1100;
      3'd4: t4 = 4'b1101;  3'd5: t4 = 4'b1010;
      3'd6: t4 = 4'b0110;  default: t4 = 4'b1110;
    endcase
  endfunction

  function automatic logic [3:0] k28t(input logic [2:0] y);
    case (y)
      3'd0: k28t = 4'b0100;  3'd1: k28t = 4'b1001;
      3'd2: k28t = 4'b0101;  3'd3: k28t = 4'b0011;
      3'd4: k28t = 4'b0010;  3'd5: k28t = 4'b1010;
      3'd6: k28t = 4'b0110;  default: k28t = 4'b1000;
    endcase
  endfunction

  function automatic logic [5:0] e6(input logic [4:0] x, input logic r);
    logic [5:0] t;
    t = t6(x);
    if (x == 5'd7 || $countones(t) != 3) e6 = r ? ~t : t;
    else e6 = t;
  endfunction

  function automatic logic [3:0] e4(input logic [2:0] y, input logic r);
    logic [3:0] t;
    t = t4(y);
    if (y == 3'd1 || y == 3'd2 || y == 3'd5 || y == 3'd6) e4 = t;
    else e4 = r ? ~t : t;
  endfunction

  // result: {err, k, byte}
  function automatic logic [9:0] dec(input logic [SYM-1:0] s, input logic r);
    logic [5:0] c6;
    logic [3:0] c4;
    logic       f6, f4, r6, a7ok;
    logic [4:0] x;
    logic [2:0] y;
    c6 = {s[0], s[1], s[2], s[3], s[4], s[5]};
    c4 = {s[6], s[7], s[8], s[9]};
    f6 = 1'b0; f4 = 1'b0; x = 5'd0; y = 3'd0;
    for (int i = 0; i < 32; i++)
      if (e6(5'(i), r) == c6) begin f6 = 1'b1; x = 5'(i); end
    r6   = r ^ ($countones(c6) != 3);
    a7ok = f6 && (r6 ? (x == 5'd11 || x == 5'd13 || x == 5'd14)
                     : (x == 5'd17 || x == 5'd18 || x == 5'd20));
    for (int j = 0; j < 8; j++)
      if (!(j == 7 && a7ok) && e4(3'(j), r6) == c4) begin f4 = 1'b1; y = 3'(j); end
    if (a7ok && c4 == (r6 ? 4'b1000 : 4'b0111)) begin f4 = 1'b1; y = 3'd7; end
    dec = {2'b10, 8'h00};
    if (c6 == (r ? 6'b110000 : 6'b001111)) begin
      for (int j = 0; j < 8; j++)
        if (c4 == (r ? ~k28t(3'(j)) : k28t(3'(j)))) dec = {2'b01, 3'(j), 5'd28};
    end else if (f6 && (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30) &&
                 c4 == (r6 ? 4'b1000 : 4'b0111)) begin
      dec = {2'b01, 3'd7, x};
    end else if (f6 && f4) begin
      dec = {2'b00, y, x};
    end
  endfunction

  function automatic logic rd_after(input logic [SYM-1:0] s, input logic r);
    if ($countones(s) > 5) rd_after = 1'b1;
    else if ($countones(s) < 5) rd_after = 1'b0;
    else rd_after = r;
  endfunction

  logic [WRD-1:0] shreg;
  logic [CW-1:0]  cnt;
  logic           aligned, rd;

  logic [WRD-1:0] sh_nx;
  logic [CW-1:0]  nb;
  logic           comma, at_bound, realign, emit, rd_mid, rd_end;
  logic [9:0]     res_lo, res_hi;

  assign sh_nx    = {ser_bit, shreg[WRD-1:1]};
  assign nb       = cnt + CW'(1);
  assign comma    = (sh_nx[SYM+6:SYM] == 7'b1111100);
  assign at_bound = aligned && (nb == CW'(SYM) || nb == CW'(WRD));
  assign realign  = comma && !at_bound;
  assign emit     = aligned && !realign && (nb == CW'(WRD));

  assign res_lo = dec(sh_nx[SYM-1:0], rd);
  assign rd_mid = rd_after(sh_nx[SYM-1:0], rd);
  assign res_hi = dec(sh_nx[WRD-1:SYM], rd_mid);
  assign rd_end = rd_after(sh_nx[WRD-1:SYM], rd_mid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      cnt        <= '0;
      aligned    <= 1'b0;
      rd         <= 1'b0;
      word_data  <= '0;
      ctl_lo     <= 1'b0;
      ctl_hi     <= 1'b0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (bit_vld) begin
        shreg <= sh_nx;
        if (realign) begin
          aligned <= 1'b1;
          cnt     <= CW'(SYM);
          rd      <= 1'b0;
        end else if (emit) begin
          cnt        <= '0;
          rd         <= rd_end;
          word_valid <= 1'b1;
          word_data  <= {res_hi[7:0], res_lo[7:0]};
          ctl_lo     <= res_lo[9] | res_lo[8];
          ctl_hi     <= res_hi[9] | res_hi[8];
        end else begin
          cnt <= (nb == CW'(WRD)) ? '0 : nb;
        end
      end
      if (los) begin
        word_data <= 16'hFFFF;
        ctl_lo    <= 1'b1;
        ctl_hi    <= 1'b1;
      end
    end
  end

  function automatic logic k_ok(input logic [7:0] b);
    k_ok = (b[4:0] == 5'd28) || b == 8'hF7 || b == 8'hFB || b == 8'hFD ||
           b == 8'hFE || b == 8'h00;
  endfunction

  a_r6_los_forces_ones: assert property (@(posedge clk) disable iff (!rst_n)
    los |=> (word_data == 16'hFFFF && ctl_lo && ctl_hi));
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);
  a_r8_no_bit_no_word: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> !word_valid);
  a_r3_lo_in_set: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !$past(los) && ctl_lo) |-> k_ok(word_data[7:0]));
  a_r3_hi_in_set: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !$past(los) && ctl_hi) |-> k_ok(word_data[15:8]));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_valid && !$past(los)) |-> $stable(word_data));

endmodule

// File: tb/sym_align_decode_tb.sv
module sym_align_decode_tb;
  logic clk = 1'b0, rst_n = 1'b0, ser_bit = 1'b0, bit_vld = 1'b0, los = 1'b0;
  logic [15:0] word_data;
  logic ctl_lo, ctl_hi, word_valid;

  always #2 clk = ~clk;

  sym_align_decode u_dut (
    .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .bit_vld(bit_vld), .los(los),
    .word_data(word_data), .ctl_lo(ctl_lo), .ctl_hi(ctl_hi), .word_valid(word_valid)
  );

  int n_chk = 0, n_fail = 0, n_words = 0, gap = 0;
  bit done = 1'b0;
  logic rd_tb = 1'b0;
  logic [17:0] exp_q[$];
  string tag_q[$];

  function automatic logic [5:0] s6(input logic [4:0] x);
    logic [5:0] tab [32];
    tab = '{6'b100111, 6'b011101, 6'b101101, 6'b110001, 6'b110101, 6'b101001,
            6'b011001, 6'b111000, 6'b111001, 6'b100101, 6'b010101, 6'b110100,
            6'b001101, 6'b101100, 6'b011100, 6'b010111, 6'b011011, 6'b100011,
            6'b010011, 6'b110010, 6'b001011, 6'b101010, 6'b011010, 6'b111010,
            6'b110011, 6'b100110, 6'b010110, 6'b110110, 6'b001110, 6'b101110,
            6'b011110, 6'b101011};
    s6 = tab[x];
  endfunction

  function automatic logic [3:0] s4(input logic [2:0] y);
    logic [3:0] tab [8];
    tab = '{4'b1011, 4'b1001, 4'b0101, 4'b1100, 4'b1101, 4'b1010, 4'b0110, 4'b1110};
    s4 = tab[y];
  endfunction

  function automatic logic [3:0] sk(input logic [2:0] y);
    logic [3:0] tab [8];
    tab = '{4'b0100, 4'b1001, 4'b0101, 4'b0011, 4'b0010, 4'b1010, 4'b0110, 4'b1000};
    sk = tab[y];
  endfunction

  // returns {rd_out, symbol}, symbol bit 0 = code bit a (sent first)
  function automatic logic [10:0] tb_enc(input logic [7:0] b, input logic k, input logic r);
    logic [5:0] c6;
    logic [3:0] c4;
    logic [9:0] s;
    logic r6, ro;
    logic [4:0] x;
    logic [2:0] y;
    x = b[4:0]; y = b[7:5];
    if (k && x == 5'd28) begin
      c6 = r ? 6'b110000 : 6'b001111;
      c4 = r ? ~sk(y) : sk(y);
    end else begin
      c6 = s6(x);
      if (x == 5'd7 || $countones(c6) != 3) c6 = r ? ~c6 : c6;
      r6 = r ^ ($countones(c6) != 3);
      if (k) c4 = r6 ? 4'b1000 : 4'b0111;
      else if (y == 3'd7 && ((!r6 && (x == 17 || x == 18 || x == 20)) ||
                             (r6 && (x == 11 || x == 13 || x == 14))))
        c4 = r6 ? 4'b1000 : 4'b0111;
      else begin
        c4 = s4(y);
        if (!(y == 1 || y == 2 || y == 5 || y == 6)) c4 = r6 ? ~c4 : c4;
      end
    end
    for (int i = 0; i < 6; i++) s[i] = c6[5-i];
    for (int i = 0; i < 4; i++) s[6+i] = c4[3-i];
    if ($countones(s) > 5) ro = 1'b1;
    else if ($countones(s) < 5) ro = 1'b0;
    else ro = r;
    tb_enc = {ro, s};
  endfunction

  function automatic logic [9:0] rev10(input logic [9:0] v);
    for (int i = 0; i < 10; i++) rev10[i] = v[9-i];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    ser_bit = b; bit_vld = 1'b1;
    @(negedge clk);
    bit_vld = 1'b0;
    gap++;
    if (gap % 5 == 0) @(negedge clk);
  endtask

  task automatic send_sym(input logic [9:0] s);
    for (int i = 0; i < 10; i++) send_bit(s[i]);
  endtask

  task automatic push(input logic [15:0] d, input logic kl, input logic kh, input string t);
    exp_q.push_back({kh, kl, d});
    tag_q.push_back(t);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic k);
    logic [10:0] e;
    e = tb_enc(b, k, rd_tb);
    rd_tb = e[10];
    send_sym(e[9:0]);
  endtask

  task automatic send_word(input logic [7:0] lo, input logic kl, input logic [7:0] hi,
                           input logic kh, input string t);
    push({hi, lo}, kl, kh, t);
    send_byte(lo, kl);
    send_byte(hi, kh);
  endtask

  always @(negedge clk) begin
    logic [17:0] e;
    string t;
    if (rst_n && word_valid) begin
      n_words++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 R10 unexpected word", {14'd0, ctl_hi, ctl_lo, word_data}, 32'd0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({ctl_hi, ctl_lo, word_data} == e, t, {14'd0, ctl_hi, ctl_lo, word_data}, {14'd0, e});
      end
    end
  end

  initial begin
    logic [10:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(word_data == 16'h0 && !ctl_lo && !ctl_hi && !word_valid, "R11 reset state",
          {13'd0, word_valid, ctl_hi, ctl_lo, word_data}, 32'd0);

    for (int i = 0; i < 6; i++) send_sym(rev10(10'b1100000101));
    repeat (5) @(negedge clk);
    check(n_words == 0, "R1 R9 inverted comma gives no word", n_words, 0);

    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    rd_tb = 1'b0;
    send_word(8'hBC, 1'b1, 8'h21, 1'b0, "R2 R9 first comma word");
    send_word(8'h12, 1'b0, 8'h34, 1'b0, "R2 data word");
    send_word(8'hFF, 1'b0, 8'h00, 1'b0, "R2 data extremes");
    send_word(8'hA5, 1'b0, 8'h5A, 1'b0, "R2 R5 disparity carried");
    send_word(8'hF1, 1'b0, 8'h8B, 1'b0, "R2 alternate 4b form");

    for (int y = 0; y < 8; y++)
      send_word({3'(y), 5'd28}, 1'b1, (y == 7) ? 8'h00 : 8'(8'h30 + y), 1'b0, "R3 K28 low lane");
    send_word(8'h11, 1'b0, 8'hF7, 1'b1, "R3 K23.7 high lane");
    send_word(8'h22, 1'b0, 8'hFB, 1'b1, "R3 K27.7 high lane");
    send_word(8'h33, 1'b0, 8'hFD, 1'b1, "R3 K29.7 high lane");
    send_word(8'h44, 1'b0, 8'hFE, 1'b1, "R3 K30.7 high lane");

    send_word(8'h4A, 1'b0, 8'hBC, 1'b1, "R10 comma in high lane");
    send_word(8'h5B, 1'b0, 8'hC3, 1'b0, "R10 alignment kept");

    push({8'h66, 8'h00}, 1'b1, 1'b0, "R4 bad low symbol");
    send_sym(rev10(10'b1111000110));
    rd_tb = 1'b1;
    send_byte(8'h66, 1'b0);

    push({8'h00, 8'h45}, 1'b0, 1'b1, "R3 R4 control outside accepted set");
    send_byte(8'h45, 1'b0);
    send_sym(rev10(10'b0011111110));
    rd_tb = 1'b1;

    push({8'h55, 8'h00}, 1'b1, 1'b0, "R5 low symbol wrong disparity");
    e = tb_enc(8'h00, 1'b0, ~rd_tb);
    send_sym(e[9:0]);
    send_byte(8'h55, 1'b0);

    push({8'h00, 8'hAA}, 1'b0, 1'b1, "R5 high symbol wrong disparity");
    send_byte(8'hAA, 1'b0);
    e = tb_enc(8'h00, 1'b0, ~rd_tb);
    send_sym(e[9:0]);

    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    rd_tb = 1'b0;
    send_word(8'hBC, 1'b1, 8'h77, 1'b0, "R10 off-boundary comma realigns");
    send_word(8'h12, 1'b0, 8'h9E, 1'b0, "R10 data after realign");

    for (int i = 0; i < 20; i++) begin
      ser_bit = ~ser_bit;
      @(negedge clk);
    end
    send_word(8'h3C, 1'b0, 8'hC5, 1'b0, "R8 idle bits ignored");

    los = 1'b1;
    @(negedge clk);
    check(word_data == 16'hFFFF && ctl_lo && ctl_hi, "R6 los forces all ones",
          {14'd0, ctl_hi, ctl_lo, word_data}, 32'h3FFFF);
    push(16'hFFFF, 1'b1, 1'b1, "R6 word under los");
    send_byte(8'h81, 1'b0);
    send_byte(8'h42, 1'b0);
    los = 1'b0;
    repeat (3) @(negedge clk);
    check(word_data == 16'hFFFF && ctl_lo && ctl_hi && !word_valid, "R7 outputs hold",
          {13'd0, word_valid, ctl_hi, ctl_lo, word_data}, 32'h3FFFF);
    send_word(8'hE7, 1'b0, 8'h18, 1'b0, "R6 decoding resumes");

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R7 all expected words seen", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule